// File: doc/BRIEF.md
# Retransmit-From-Mark FIFO Read Controller

This block is a single-clock FIFO whose read side can remember one stored word and later replay the stream from that word. When the mark input is held high while a word sits in the output register, that word's address is captured. The controller then enters retransmit mode. While the mode lasts, the captured address acts as a write barrier: the writer sees the FIFO as full rather than overwrite any word from the mark onward. A retransmit request makes the read pointer jump back to the mark. During this fixed three-cycle setup interval the availability flag is held low.

Two read timings are supported and are chosen by a static mode input. In standard timing, every word, including the first word after a retransmit, must be pulled out by a read enable. In fall-through timing, the next word is presented on its own with the availability flag high, and a read enable consumes it. Dropping the mark input ends retransmit mode and releases the barrier. Raising it again sets a new mark, which replaces the old one.

Top module: `rtm_fifo_rd_ctrl`

## Requirements
- R1: During and after reset, `data_avail`, `full` and `rt_mode` are 0 and `rd_data` is 0.
- R2: In standard timing (`fall_through`=0), a rising edge with `rd_en`=1 and `data_avail`=1 places the oldest unread word on `rd_data` after that edge. With `data_avail`=0, `rd_en` leaves `rd_data` unchanged.
- R3: In standard timing, an edge with `mark`=1 and `data_avail`=1, after at least one word has been read since reset or since the last retransmit, sets `rt_mode`=1. The word then on `rd_data` becomes the marked word.
- R4: In fall-through timing (`fall_through`=1), an edge with `mark`=1 while `data_avail`=1 sets `rt_mode`=1. The word on `rd_data` becomes the marked word.
- R5: `rt_mode` stays 1 while `mark` is 1. It returns to 0 on the first edge with `mark`=0 that falls outside a retransmit setup; a low `mark` during setup takes effect only after setup ends.
- R6: A mark taken after `rt_mode` has returned to 0 replaces the previous mark, and a later retransmit replays from the new word.
- R7: `rt_req`=1 starts a retransmit only on an edge where `rt_mode`=1, `mark`=1, `rd_en`=0 and no setup is running. Otherwise it has no effect on `data_avail` or `rd_data`.
- R8: After a retransmit starts, `data_avail` is 0 for exactly three cycles. Afterwards, in standard timing, the next `rd_en` returns the marked word, followed by the words written after it in order.
- R9: In fall-through timing, when setup ends, `data_avail`=1 and `rd_data` holds the marked word with no read enable applied.
- R10: While `rt_mode`=1, `full` is 1 once the words from the marked word to the newest written word fill all DEPTH slots. A write attempted then changes no stored word.
- R11: Outside retransmit mode, `full` is 1 when DEPTH words are unread, and a write attempted then is dropped.
- R12: In fall-through timing, a word written into an empty FIFO appears on `rd_data` with `data_avail`=1 one cycle after the write edge.

Top module port order follows the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fall_through | input | 1 | 1 selects fall-through read timing; change only during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free slot, or the next slot would overwrite the marked word |
| rd_en | input | 1 | Read request / consume presented word |
| rd_data | output | DATA_W | Output register |
| data_avail | output | 1 | Words can be read (standard) or `rd_data` is valid (fall-through); low during retransmit setup |
| mark | input | 1 | Level input: capture mark and hold retransmit mode |
| rt_req | input | 1 | Retransmit request |
| rt_mode | output | 1 | Retransmit mode active |

## Verification
Every result of this block is registered, so `rd_data`, `data_avail`, `full` and `rt_mode` change on the edge that samples the stimulus. The exception is a fall-through word written into an empty FIFO, which appears one edge after its write edge. After a retransmit is accepted, `data_avail` stays low across the three following edges and rises on the fourth. The bench drives each stimulus 1 ns after a rising edge and reads the outputs 1 ns after the next one. The expected values in the vector table and in the directed tests are placed at those edge counts. A mark input that is released during setup is checked for one extra edge, so that the deferred exit is observed on the exact edge where it is due.

// File: rtl/rtm_pkg.sv
// Shared types for the retransmit-from-mark FIFO read controller.
// Assumes: one clock domain, setup sequence of fixed length three.
package rtm_pkg;

    // Retransmit setup sequencer: idle, then three setup cycles.
    typedef enum logic [1:0] {
        RT_IDLE   = 2'd0,
        RT_RELOAD = 2'd1,
        RT_FILL   = 2'd2,
        RT_SETTLE = 2'd3
    } rt_state_e;

endpackage

// File: rtl/rtm_store.sv
// Storage array of the FIFO: one synchronous write port, one
// asynchronous read port. Assumes the caller never writes a slot it
// still needs (the write guard enforces this). No reset on contents.
module rtm_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the word at the read address.
    assign rdata = mem[raddr];

endmodule

// File: rtl/rtm_wr_guard.sv
// Write pointer and full decision. Outside retransmit mode the limit
// is the read pointer; inside it the limit is the mark pointer, so no
// write may land on the marked word or anything after it.
// Assumes pointers carry one extra wrap bit.
module rtm_wr_guard #(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            marked,
    input  logic [ADDR_W:0] rptr,
    input  logic [ADDR_W:0] mptr,
    output logic [ADDR_W:0] wptr,
    output logic            full,
    output logic            wr_accept
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] limit;
    logic [PTR_W-1:0] span;

    // Pick the barrier: mark while retransmit mode holds, else read side.
    always_comb begin
        limit = marked ? mptr : rptr;
        span  = wptr_q - limit;
        full  = (span == DEPTH_P);
    end

    assign wr_accept = wr_en && !full;

    // Advance the write pointer on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (wr_accept) begin
            wptr_q <= wptr_q + PTR_W'(1);
        end
    end

    assign wptr = wptr_q;

endmodule

// File: rtl/rtm_mark_ctrl.sv
// Mark capture, retransmit-mode flag and the three-cycle retransmit
// setup sequencer. Assumes mark_ok already reflects the timing mode
// (a valid word sits in the output register).
module rtm_mark_ctrl
    import rtm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mark,
    input  logic            rt_req,
    input  logic            rd_en,
    input  logic            mark_ok,
    input  logic [ADDR_W:0] rptr,
    output logic            marked,
    output logic [ADDR_W:0] mptr,
    output logic            in_setup,
    output logic            reload,
    output logic            preload
);
    localparam int PTR_W = ADDR_W + 1;

    rt_state_e        st_q;
    logic             marked_q;
    logic [PTR_W-1:0] mptr_q;
    logic             start;

    // A retransmit is accepted only in mode, mark held, reads idle.
    assign start = marked_q && mark && rt_req && !rd_en && (st_q == RT_IDLE);

    // Step the setup sequence: reload pointer, refill output, settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RT_IDLE;
        end else begin
            unique case (st_q)
                RT_IDLE:   st_q <= start ? RT_RELOAD : RT_IDLE;
                RT_RELOAD: st_q <= RT_FILL;
                RT_FILL:   st_q <= RT_SETTLE;
                default:   st_q <= RT_IDLE;
            endcase
        end
    end

    // Capture the mark on entry; leave the mode when mark drops outside setup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marked_q <= 1'b0;
            mptr_q   <= '0;
        end else if (!marked_q) begin
            if (mark && mark_ok) begin
                marked_q <= 1'b1;
                mptr_q   <= rptr - PTR_W'(1);
            end
        end else if (!mark && (st_q == RT_IDLE)) begin
            marked_q <= 1'b0;
        end
    end

    assign marked   = marked_q;
    assign mptr     = mptr_q;
    assign in_setup = (st_q != RT_IDLE);
    assign reload   = (st_q == RT_RELOAD);
    assign preload  = (st_q == RT_FILL);

endmodule

// File: rtl/rtm_rd_path.sv
// Read pointer, output register and availability flag for both read
// timings. Standard: rd_en loads the next word. Fall-through: the next
// word is fetched on its own and rd_en consumes it. During setup all
// normal reads are frozen; reload/preload come from the mark control.
module rtm_rd_path #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_through,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wptr,
    input  logic [ADDR_W:0]   mptr,
    input  logic              in_setup,
    input  logic              reload,
    input  logic              preload,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W:0]   rptr,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_avail,
    output logic              mark_ok
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  rptr_q;
    logic [DATA_W-1:0] dout_q;
    logic              vld_q;
    logic              loaded_q;
    logic [PTR_W-1:0]  fill;
    logic              has_words;
    logic              std_rd;
    logic              ft_fetch;
    logic              ft_drop;

    // Decode what the read side does this cycle.
    always_comb begin
        fill      = wptr - rptr_q;
        has_words = (fill != '0);
        std_rd    = !fall_through && !in_setup && rd_en && has_words;
        ft_fetch  = fall_through && !in_setup && has_words && (!vld_q || rd_en);
        ft_drop   = fall_through && !in_setup && rd_en && vld_q && !has_words;
    end

    // Update pointer and output register; setup actions take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q   <= '0;
            dout_q   <= '0;
            vld_q    <= 1'b0;
            loaded_q <= 1'b0;
        end else if (reload) begin
            rptr_q   <= mptr;
            vld_q    <= 1'b0;
            loaded_q <= 1'b0;
        end else if (preload && fall_through) begin
            dout_q <= mem_rdata;
            rptr_q <= rptr_q + PTR_W'(1);
            vld_q  <= 1'b1;
        end else if (std_rd) begin
            dout_q   <= mem_rdata;
            rptr_q   <= rptr_q + PTR_W'(1);
            loaded_q <= 1'b1;
        end else if (ft_fetch) begin
            dout_q <= mem_rdata;
            rptr_q <= rptr_q + PTR_W'(1);
            vld_q  <= 1'b1;
        end else if (ft_drop) begin
            vld_q <= 1'b0;
        end
    end

    // Flags toward the ports and the mark control.
    always_comb begin
        data_avail = !in_setup && (fall_through ? vld_q : has_words);
        mark_ok    = !in_setup && (fall_through ? vld_q : (has_words && loaded_q));
    end

    assign rptr    = rptr_q;
    assign rd_data = dout_q;

endmodule

// File: rtl/rtm_fifo_rd_ctrl.sv
// Top of the retransmit-from-mark FIFO: storage, write guard, read
// path and mark control. Assumes fall_through is held stable outside
// reset and that all ports share clk.
module rtm_fifo_rd_ctrl #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_through,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_avail,
    input  logic              mark,
    input  logic              rt_req,
    output logic              rt_mode
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic [PTR_W-1:0]  mptr;
    logic              wr_accept;
    logic              marked;
    logic              in_setup;
    logic              reload;
    logic              preload;
    logic              mark_ok;
    logic [DATA_W-1:0] mem_rdata;

    rtm_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (wr_accept),
        .waddr (wptr[ADDR_W-1:0]),
        .wdata (wr_data),
        .raddr (rptr[ADDR_W-1:0]),
        .rdata (mem_rdata)
    );

    rtm_wr_guard #(.ADDR_W(ADDR_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .marked    (marked),
        .rptr      (rptr),
        .mptr      (mptr),
        .wptr      (wptr),
        .full      (full),
        .wr_accept (wr_accept)
    );

    rtm_rd_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .fall_through (fall_through),
        .rd_en        (rd_en),
        .wptr         (wptr),
        .mptr         (mptr),
        .in_setup     (in_setup),
        .reload       (reload),
        .preload      (preload),
        .mem_rdata    (mem_rdata),
        .rptr         (rptr),
        .rd_data      (rd_data),
        .data_avail   (data_avail),
        .mark_ok      (mark_ok)
    );

    rtm_mark_ctrl #(.ADDR_W(ADDR_W)) u_mark (
        .clk      (clk),
        .rst_n    (rst_n),
        .mark     (mark),
        .rt_req   (rt_req),
        .rd_en    (rd_en),
        .mark_ok  (mark_ok),
        .rptr     (rptr),
        .marked   (marked),
        .mptr     (mptr),
        .in_setup (in_setup),
        .reload   (reload),
        .preload  (preload)
    );

    assign rt_mode = marked;

endmodule

// File: rtl/rtm_fifo_rd_ctrl_chk.sv
// Property checker for rtm_fifo_rd_ctrl, attached by bind below.
// Observes ports and the pointers passed between sub-blocks.
module rtm_fifo_rd_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mark,
    input logic            data_avail,
    input logic            full,
    input logic            rt_mode,
    input logic            in_setup,
    input logic [ADDR_W:0] wptr,
    input logic [ADDR_W:0] rptr,
    input logic [ADDR_W:0] mptr
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

    // R1: reset leaves every flag low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!data_avail && !full && !rt_mode));

    // R5: mode cannot end while mark is held
    a_r5_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_mode && mark) |=> rt_mode);

    // R7: setup only runs inside retransmit mode
    a_r7_setup_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
        in_setup |-> rt_mode);

    // R8: availability is low throughout setup
    a_r8_setup_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        in_setup |-> !data_avail);

    // R8: setup lasts exactly three cycles
    a_r8_setup_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_setup) |=> in_setup ##1 in_setup ##1 !in_setup);

    // R10: writer never passes the marked word
    a_r10_barrier: assert property (@(posedge clk) disable iff (!rst_n)
        rt_mode |-> (PTR_W'(wptr - mptr) <= DEPTH_P));

    // R11: unread words never exceed the depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(wptr - rptr) <= DEPTH_P);

endmodule

bind rtm_fifo_rd_ctrl rtm_fifo_rd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark       (mark),
    .data_avail (data_avail),
    .full       (full),
    .rt_mode    (rt_mode),
    .in_setup   (in_setup),
    .wptr       (wptr),
    .rptr       (rptr),
    .mptr       (mptr)
);

// File: tb/sim_rtm_fifo_rd_ctrl.sv
module sim_rtm_fifo_rd_ctrl;
    localparam int DW = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fall_through = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          full;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          data_avail;
    logic          mark = 1'b0;
    logic          rt_req = 1'b0;
    logic          rt_mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rtm_fifo_rd_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .fall_through(fall_through),
        .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .data_avail(data_avail),
        .mark(mark), .rt_req(rt_req), .rt_mode(rt_mode)
    );

    // Standard-timing vectors: {wr,rd,mark,rt}, wdata, {avail,full,mode,chkdata}, data
    localparam logic [23:0] VEC [20] = '{
        {4'b1000, 8'h11, 4'b1000, 8'h00},
        {4'b1000, 8'h22, 4'b1000, 8'h00},
        {4'b0100, 8'h00, 4'b1001, 8'h11},
        {4'b0010, 8'h00, 4'b1011, 8'h11},
        {4'b1010, 8'h33, 4'b1010, 8'h00},
        {4'b1010, 8'h44, 4'b1110, 8'h00},
        {4'b1010, 8'h55, 4'b1110, 8'h00},
        {4'b0110, 8'h00, 4'b1111, 8'h22},
        {4'b0110, 8'h00, 4'b1111, 8'h33},
        {4'b0011, 8'h00, 4'b0110, 8'h00},
        {4'b0010, 8'h00, 4'b0110, 8'h00},
        {4'b0010, 8'h00, 4'b0110, 8'h00},
        {4'b0010, 8'h00, 4'b1110, 8'h00},
        {4'b0110, 8'h00, 4'b1111, 8'h11},
        {4'b0110, 8'h00, 4'b1111, 8'h22},
        {4'b0000, 8'h00, 4'b1000, 8'h00},
        {4'b1000, 8'h55, 4'b1000, 8'h00},
        {4'b0100, 8'h00, 4'b1001, 8'h33},
        {4'b0100, 8'h00, 4'b1001, 8'h44},
        {4'b0100, 8'h00, 4'b0001, 8'h55}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, pass one rising edge, land 1 ns after it.
    task automatic step(input logic w, input logic r, input logic m, input logic t,
                        input logic [DW-1:0] d);
        wr_en = w; rd_en = r; mark = m; rt_req = t; wr_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic ft);
        rst_n = 1'b0; fall_through = ft;
        wr_en = 0; rd_en = 0; mark = 0; rt_req = 0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 avail", 16'(data_avail), 16'd0);
        chk("R1 full", 16'(full), 16'd0);
        chk("R1 mode", 16'(rt_mode), 16'd0);
        chk("R1 data", 16'(rd_data), 16'd0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Table walk in standard timing: R2 R3 R8 R10 R5
        do_reset(1'b0);
        for (int i = 0; i < 20; i++) begin
            logic [23:0] v;
            v = VEC[i];
            step(v[23], v[22], v[21], v[20], v[19:12]);
            chk($sformatf("R8 avail v%0d", i), 16'(data_avail), 16'(v[11]));
            chk($sformatf("R10 full v%0d", i), 16'(full), 16'(v[10]));
            chk($sformatf("R3 mode v%0d", i), 16'(rt_mode), 16'(v[9]));
            if (v[8]) chk($sformatf("R2 data v%0d", i), 16'(rd_data), 16'(v[7:0]));
        end

        // R2: read on empty is ignored
        do_reset(1'b0);
        step(0, 1, 0, 0, 8'h00);
        chk("R2 empty read data", 16'(rd_data), 16'd0);
        chk("R2 empty read avail", 16'(data_avail), 16'd0);

        // R11: normal full, fifth write dropped
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, DW'(8'hA0 + i));
        chk("R11 full at depth", 16'(full), 16'd1);
        step(1, 0, 0, 0, 8'hEE);
        chk("R11 full held", 16'(full), 16'd1);
        for (int i = 0; i < 4; i++) begin
            step(0, 1, 0, 0, 8'h00);
            chk("R11 order", 16'(rd_data), 16'(8'hA0 + i));
        end
        chk("R11 drained", 16'(data_avail), 16'd0);
        chk("R11 not full", 16'(full), 16'd0);

        // Fall-through timing: R12 R4 R7 R9 R5 R6
        do_reset(1'b1);
        step(1, 0, 0, 0, 8'hB0);
        chk("R12 not yet shown", 16'(data_avail), 16'd0);
        step(0, 0, 0, 0, 8'h00);
        chk("R12 shown avail", 16'(data_avail), 16'd1);
        chk("R12 shown data", 16'(rd_data), 16'hB0);
        step(1, 0, 0, 0, 8'hB1);
        step(1, 0, 0, 0, 8'hB2);
        chk("R12 head kept", 16'(rd_data), 16'hB0);
        step(0, 0, 1, 0, 8'h00);
        chk("R4 mode entered", 16'(rt_mode), 16'd1);
        step(0, 1, 1, 1, 8'h00);
        chk("R7 rt with read ignored avail", 16'(data_avail), 16'd1);
        chk("R7 rt with read ignored data", 16'(rd_data), 16'hB1);
        step(0, 1, 1, 0, 8'h00);
        chk("R4 consume", 16'(rd_data), 16'hB2);
        step(0, 0, 1, 1, 8'h00);
        chk("R8 setup c1", 16'(data_avail), 16'd0);
        step(0, 0, 1, 0, 8'h00);
        chk("R8 setup c2", 16'(data_avail), 16'd0);
        step(0, 0, 1, 0, 8'h00);
        chk("R8 setup c3", 16'(data_avail), 16'd0);
        step(0, 0, 1, 0, 8'h00);
        chk("R9 avail after setup", 16'(data_avail), 16'd1);
        chk("R9 marked word shown", 16'(rd_data), 16'hB0);
        step(0, 1, 0, 0, 8'h00);
        chk("R5 exit on low mark", 16'(rt_mode), 16'd0);
        chk("R5 next word", 16'(rd_data), 16'hB1);
        step(0, 0, 1, 0, 8'h00);
        chk("R6 remark", 16'(rt_mode), 16'd1);
        step(0, 0, 1, 1, 8'h00);
        chk("R8 second setup", 16'(data_avail), 16'd0);
        step(0, 0, 0, 0, 8'h00);
        chk("R5 held during setup a", 16'(rt_mode), 16'd1);
        step(0, 0, 0, 0, 8'h00);
        chk("R5 held during setup b", 16'(rt_mode), 16'd1);
        step(0, 0, 0, 0, 8'h00);
        chk("R5 held during setup c", 16'(rt_mode), 16'd1);
        chk("R6 new mark replayed", 16'(rd_data), 16'hB1);
        chk("R6 avail", 16'(data_avail), 16'd1);
        step(0, 0, 0, 0, 8'h00);
        chk("R5 deferred exit", 16'(rt_mode), 16'd0);

        // R7: rt outside retransmit mode is ignored
        step(0, 0, 0, 1, 8'h00);
        chk("R7 no mode no setup", 16'(data_avail), 16'd1);
        chk("R7 data kept", 16'(rd_data), 16'hB1);

        finish_run();
    end

endmodule